// File: doc/BRIEF.md
# MDIO Command-Register Master

This block lets a host run Clause-22 management transactions against external PHYs or switch ports through one 32-bit word. The host writes a command word that holds a PHY address, a register address, an operation bit and, for writes, sixteen bits of payload. The write starts a serial frame on the management clock and data lines at once. The same word, read back, shows whether a frame is still running, whether a completed read has left data behind, and what that data is.

Internally a clock divider produces the management clock from the system clock. A control sequencer counts frame bit slots and issues strobes. A datapath holds the command fields, a transmit shift register and a receive shift register. The data line is driven through an output-enable so that the PHY can take the line for the turnaround and data slots of a read.

Top module: `mdio_cmd_master`

## Requirements
- R1: Command word layout: bits 20:16 are the PHY address, bits 25:21 the register address, and bit 26 the operation (1 = read, 0 = write). On readback, bits 26:16 show the last accepted command and bits 31:29 read as zero.
- R2: A host write accepted while idle sets the busy flag (bit 28) in the readback from the next clock onward. It stays set until the frame ends.
- R3: Each frame is 32 ones, then 01, then 10 for a read or 01 for a write, then the 5 PHY address bits and the 5 register address bits MSB first. A write then sends turnaround 10 and bits 15:0 of the command MSB first, giving 64 slots in all.
- R4: On a read, the output enable is dropped for the last 18 slots (turnaround and data), and the line is sampled on each rising MDC edge of the 16 data slots. When the frame ends, busy clears, read-valid (bit 27) sets in the same cycle, and bits 15:0 return the sampled value.
- R5: When a write frame ends, busy clears and read-valid stays 0.
- R6: A host write while busy is 1 is ignored: the running frame, the readback fields and the later line activity are unchanged.
- R7: Accepting any command clears read-valid. Once set, read-valid stays set until the next command is accepted.
- R8: MDC is high for DIV_HALF system clocks and low for DIV_HALF system clocks. The default of 10 gives 2.5 MHz from a 50 MHz clock.
- R9: The data line value and its output enable change only in the cycle where MDC falls.
- R10: Written bits 31:27 have no effect. Bits 15:0 of a read command never reach the line.
- R11: After reset the readback word is zero, MDC is low and the output enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe for the command word |
| regWrData | input | 32 | Command word written by the host |
| regRdData | output | 32 | Status, command fields and read data |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven value |
| mdioOe | output | 1 | Output enable for the management data line |
| mdioIn | input | 1 | Management data line as seen at the pin |

## Verification
The bench builds the block with DIV_HALF set to 3 and the default 32-bit preamble. The short half period keeps each 64-slot frame near 400 clocks, so a single run can hold several writes and reads, a write attempt in the middle of a frame, and a long hold of read-valid. A bench PHY model with its own register file answers reads. Round trips through it show that payload bits land in the right order. The odd half period also checks that the divider has no hidden assumption of an even count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BUSY_BIT   = 28;
  localparam int RVALID_BIT = 27;
  localparam int OP_BIT     = 26;
  localparam int REG_LSB    = 21;
  localparam int PHY_LSB    = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rstN,
  output logic mdc,
  output logic riseTick,
  output logic fallTick
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] divCnt;
  logic          mdcR;
  logic          wrap;

  assign wrap = (divCnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      mdcR   <= 1'b0;
    end else if (wrap) begin
      divCnt <= '0;
      mdcR   <= ~mdcR;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Ticks mark the clock edge on which mdc toggles.
  assign riseTick = wrap & ~mdcR;
  assign fallTick = wrap &  mdcR;
  assign mdc      = mdcR;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        riseTick,
  input  logic        fallTick,
  input  logic        cmdRead,
  output mdioStrobe_t strb,
  output logic        busy,
  output logic        rdValid,
  output logic        oe
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int TA_IDX     = PRE_BITS + 14;
  localparam int DATA_IDX   = PRE_BITS + 16;
  localparam int LAST_IDX   = FRAME_BITS - 1;

  seqState_t   st;
  logic [BW-1:0] bitCnt;
  logic        oeR;
  logic        rdValidR;
  logic        atLast;

  assign atLast = (bitCnt == BW'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      oeR      <= 1'b0;
      rdValidR <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (hostWr) begin
            st       <= ST_ALIGN;
            rdValidR <= 1'b0;
          end
        end
        ST_ALIGN: begin
          if (fallTick) begin
            st     <= ST_RUN;
            bitCnt <= '0;
            oeR    <= 1'b1;
          end
        end
        ST_RUN: begin
          if (fallTick) begin
            if (atLast) begin
              st       <= ST_IDLE;
              oeR      <= 1'b0;
              rdValidR <= cmdRead;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              if (cmdRead && bitCnt == BW'(TA_IDX - 1)) oeR <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = (st == ST_IDLE) && hostWr;
    strb.shift   = (st == ST_RUN) && fallTick && !atLast;
    strb.capture = (st == ST_RUN) && riseTick && cmdRead &&
                   (bitCnt >= BW'(DATA_IDX));
  end

  assign busy    = (st != ST_IDLE);
  assign rdValid = rdValidR;
  assign oe      = oeR;
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic [26:0] cmdIn,
  input  logic        mdioIn,
  output logic        txBit,
  output logic        cmdRead,
  output logic [10:0] cmdFields,
  output logic [15:0] rxData
);
  localparam int FRAME_BITS = PRE_BITS + 32;

  logic [FRAME_BITS-1:0] txShift;
  logic [10:0]           cmdReg;
  logic [15:0]           rxShift;
  logic                  newRead;
  logic [FRAME_BITS-1:0] frameImg;

  assign newRead = cmdIn[OP_BIT];

  always_comb begin
    frameImg = {{PRE_BITS{1'b1}}, 2'b01,
                newRead ? 2'b10 : 2'b01,
                cmdIn[PHY_LSB +: 5], cmdIn[REG_LSB +: 5],
                2'b10,
                newRead ? 16'hFFFF : cmdIn[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      cmdReg  <= '0;
      rxShift <= '0;
    end else begin
      if (strb.load) begin
        txShift <= frameImg;
        cmdReg  <= cmdIn[26:16];
        rxShift <= '0;
      end else begin
        if (strb.shift)   txShift <= {txShift[FRAME_BITS-2:0], 1'b1};
        if (strb.capture) rxShift <= {rxShift[14:0], mdioIn};
      end
    end
  end

  assign txBit     = txShift[FRAME_BITS-1];
  assign cmdRead   = cmdReg[10];
  assign cmdFields = cmdReg;
  assign rxData    = rxShift;
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 10,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t strb;
  logic        riseTick;
  logic        fallTick;
  logic        cmdRead;
  logic        busy;
  logic        rdValid;
  logic        oe;
  logic        txBit;
  logic [10:0] cmdFields;
  logic [15:0] rxData;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) uDiv (
    .clk(clk), .rstN(rstN), .mdc(mdc),
    .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl #(.PRE_BITS(PRE_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWr(regWrEn),
    .riseTick(riseTick), .fallTick(fallTick), .cmdRead(cmdRead),
    .strb(strb), .busy(busy), .rdValid(rdValid), .oe(oe)
  );

  mdio_dpath #(.PRE_BITS(PRE_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIn(regWrData[26:0]),
    .mdioIn(mdioIn), .txBit(txBit), .cmdRead(cmdRead),
    .cmdFields(cmdFields), .rxData(rxData)
  );

  assign regRdData = {3'b000, busy, rdValid, cmdFields, rxData};
  assign mdioOut   = txBit & oe;
  assign mdioOe    = oe;
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regRdData,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[28] && regWrEn) |=> (regRdData[28] && !regRdData[27]));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[28] && regWrEn) |=> $stable(regRdData[26:16]));

  // R9
  line_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mdioOe) || !$stable(mdioOut)) |-> $fell(mdc));

  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[28] |-> !mdioOe);

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdData[28] && regRdData[27]));

  // R7
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[27] && !regWrEn) |=> regRdData[27]);
endmodule

bind mdio_cmd_master mdio_cmd_master_chk uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        mdioIn = 1'b1;
  wire  [31:0] regRdData;
  wire         mdc, mdioOut, mdioOe;

  always #10 clk = ~clk;

  mdio_cmd_master #(.DIV_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oeMask;
  } frame_t;

  frame_t      expQ[$];
  logic [15:0] phyMem[32];
  logic [15:0] refMem[32];
  int          framesSeen = 0;
  int          edgeViol = 0;

  // PHY model and monitor
  logic        prevMdc = 0, prevOut = 0, prevOe = 0, inFrame = 0, isRd = 0;
  int          cnt = 0;
  logic [63:0] gotBits = '0, gotOe = '0;
  logic [15:0] rdVal = '0;
  logic [4:0]  ra = '0;

  initial begin
    for (int i = 0; i < 32; i++) begin
      phyMem[i] = 16'hA500 ^ 16'(i * 16'h0123);
      refMem[i] = 16'hA500 ^ 16'(i * 16'h0123);
    end
    forever begin
      @(negedge clk);
      if (rstN && (mdioOut != prevOut || mdioOe != prevOe) && !(prevMdc && !mdc))
        edgeViol++;
      if (mdc && !prevMdc) begin
        if (!inFrame && mdioOe) begin
          inFrame = 1; cnt = 0;
        end
        if (inFrame) begin
          gotBits = {gotBits[62:0], mdioOut};
          gotOe   = {gotOe[62:0], mdioOe};
          cnt++;
          if (cnt == 46) begin
            ra    = gotBits[4:0];
            isRd  = (gotBits[11:10] == 2'b10);
            rdVal = phyMem[ra];
          end
          if (cnt == 64) begin
            inFrame = 0;
            framesSeen++;
            if (expQ.size() == 0) begin
              chk(0, "R6", "unexpected frame", gotBits, 0);
            end else begin
              frame_t e;
              e = expQ.pop_front();
              chk(gotOe == e.oeMask, "R4", "output enable pattern", gotOe, e.oeMask);
              chk(((gotBits ^ e.bits) & e.oeMask) == 0, "R3", "frame bits",
                  gotBits & e.oeMask, e.bits & e.oeMask);
            end
            if (!isRd) phyMem[ra] = gotBits[15:0];
          end
        end
      end else if (!mdc && prevMdc) begin
        if (inFrame && isRd && cnt == 47) mdioIn = 1'b0;
        else if (inFrame && isRd && cnt >= 48 && cnt <= 63) mdioIn = rdVal[63 - cnt];
        else mdioIn = 1'b1;
      end
      prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
    end
  end

  task automatic waitIdle();
    int n = 0;
    while (regRdData[28] && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(!regRdData[28], "R2", "busy eventually clears", regRdData[28], 0);
  endtask

  task automatic sendCmd(input logic rd, input logic [4:0] pa, input logic [4:0] rg,
                         input logic [15:0] d, input logic [4:0] junk, input bit poke);
    frame_t f;
    f.bits   = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, rg, 2'b10, rd ? 16'h0 : d};
    f.oeMask = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    expQ.push_back(f);
    @(negedge clk);
    regWrData = {junk, rd, rg, pa, d};
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    chk(regRdData[28] == 1'b1, "R2", "busy after launch", regRdData[28], 1);
    chk(regRdData[27] == 1'b0, "R7", "read-valid cleared on accept", regRdData[27], 0);
    chk(regRdData[31:29] == 3'b0, "R10", "reserved readback", regRdData[31:29], 0);
    chk(regRdData[26:16] == {rd, rg, pa}, "R1", "command fields", regRdData[26:16], {rd, rg, pa});
    if (poke) begin
      repeat (40) @(negedge clk);
      regWrData = {5'b0, 1'b0, 5'd7, 5'd2, 16'hDEAD};
      regWrEn = 1'b1;
      @(negedge clk);
      regWrEn = 1'b0;
    end
    waitIdle();
    chk(regRdData[26:16] == {rd, rg, pa}, "R6", "fields kept after busy write",
        regRdData[26:16], {rd, rg, pa});
    if (rd) begin
      chk(regRdData[27] == 1'b1, "R4", "read-valid set", regRdData[27], 1);
      chk(regRdData[15:0] == refMem[rg], "R4", "read data", regRdData[15:0], refMem[rg]);
    end else begin
      refMem[rg] = d;
      chk(regRdData[27] == 1'b0, "R5", "no read-valid after write", regRdData[27], 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin : main
    int hi, lo;
    repeat (4) @(negedge clk);
    chk(regRdData == 32'h0, "R11", "readback in reset", regRdData, 0);
    chk(mdioOe == 1'b0, "R11", "oe in reset", mdioOe, 0);
    chk(mdc == 1'b0, "R11", "mdc in reset", mdc, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(regRdData == 32'h0, "R11", "readback after reset", regRdData, 0);

    // R8: measure one high and one low phase
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    hi = 0;
    while (mdc) begin hi++; @(negedge clk); end
    lo = 0;
    while (!mdc) begin lo++; @(negedge clk); end
    chk(hi == HALF, "R8", "mdc high clocks", hi, HALF);
    chk(lo == HALF, "R8", "mdc low clocks", lo, HALF);

    sendCmd(1'b0, 5'h11, 5'd3, 16'hBEEF, 5'b00000, 0);  // R3 R5
    sendCmd(1'b1, 5'h11, 5'd3, 16'h1234, 5'b00000, 0);  // R4 R10: payload ignored
    repeat (60) @(negedge clk);
    chk(regRdData[27] == 1'b1, "R7", "read-valid held", regRdData[27], 1);
    sendCmd(1'b0, 5'h00, 5'h1F, 16'h0001, 5'b11111, 1); // R6 R7 R10
    sendCmd(1'b1, 5'h1F, 5'd7, 16'hFFFF, 5'b00000, 0);  // R6: reg 7 untouched
    sendCmd(1'b1, 5'h0A, 5'h1F, 16'h0000, 5'b10100, 0);
    sendCmd(1'b0, 5'h15, 5'd7, 16'h8000, 5'b00000, 0);
    sendCmd(1'b1, 5'h15, 5'd7, 16'h0000, 5'b00000, 0);

    repeat (100) @(negedge clk);
    chk(framesSeen == 7, "R6", "frame count", framesSeen, 7);
    chk(edgeViol == 0, "R9", "line changes off falling edge", edgeViol, 0);
    chk(expQ.size() == 0, "R3", "all frames observed", expQ.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule